// File: doc/BRIEF.md
# External Bus Idle-State Sequencer

This block runs external bus cycles for a small CPU bus controller. Each request names a target area (0 to 7), says whether it is a read or a write, and says whether it targets DRAM space. The block runs each accepted request as a bus cycle of two or three states. The per-area speed setting picks the length. The block drives the read and write strobes, a state indicator and the area under access.

Some devices keep driving the data bus for a while after their read ends. To protect against this, the sequencer can put one idle state (Ti) in front of a new cycle. It does this when the new cycle follows, with no gap, a cycle that could still be driving the bus. The trigger is one of three cases: a read after a read to another area, a write after a read, or a non-DRAM access after a DRAM access. Each case has its own enable bit, and all three enables are on after reset. Software can clear an enable when its collision risk does not exist.

Top module: `bus_idle_seq`

## Requirements
- R1: After reset, bus_state is IDLE (0), both strobes are low and req_ready is high. All three idle rules are enabled, and every area runs three-state cycles.
- R2: A cycle runs T1 (2), T2 (3) and, when bit N of the slow-area setting is 1 for area N, also T3 (4). bus_state then returns to IDLE or goes straight on to the next cycle.
- R3: With the read-read rule enabled, a read that directly follows a read to a different area starts with one Ti (1). A read that follows a read to the same area gets no Ti from this rule.
- R4: With the write-after-read rule enabled, a write that directly follows a read starts with one Ti. A write that directly follows a write gets no Ti.
- R5: With the DRAM rule enabled, a non-DRAM access that directly follows a DRAM access starts with one Ti. A DRAM access after a DRAM access gets no Ti from this rule.
- R6: Clearing an enable bit stops insertion for its case. Loading the configuration with cfg_we updates all four settings at once.
- R7: A Ti lasts exactly one clock. Both strobes are low during it, bus_area already shows the new area, and T1 follows.
- R8: History counts only when cycles are back to back. A request accepted from IDLE never gets a Ti.
- R9: rd_o is high in every state of a read cycle from T1 onward. wr_o is high in T2 and T3 of a write cycle. The two strobes are never high together.
- R10: req_ready is high in IDLE and in the final state of a cycle, and low in every other state. A request presented in the final state is accepted at that clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Loads the four configuration settings |
| cfg_rr_in | input | 1 | Enable for the read-after-read-to-another-area rule |
| cfg_wr_in | input | 1 | Enable for the write-after-read rule |
| cfg_dram_in | input | 1 | Enable for the non-DRAM-after-DRAM rule |
| cfg_slow_in | input | 8 | Per-area three-state select, bit N for area N |
| req_valid | input | 1 | A request is presented |
| req_ready | output | 1 | The request is accepted at this edge if valid |
| req_area | input | 3 | Target area of the request |
| req_write | input | 1 | 1 for write, 0 for read |
| req_dram | input | 1 | Request targets DRAM space |
| bus_state | output | 3 | 0 IDLE, 1 Ti, 2 T1, 3 T2, 4 T3 |
| bus_area | output | 3 | Area of the cycle in progress |
| rd_o | output | 1 | Read strobe, active high |
| wr_o | output | 1 | Write strobe, active high |

## Verification
The hardest case to reach is a decision made in the final state of the running cycle. The new request must be waiting when req_ready rises there, or the history is lost and no Ti can appear. Each scenario task therefore presents the second request while the first cycle is still in progress and holds req_valid until that final state. A variant lets the bus drop to IDLE first, to show that the history is forgotten after the gap.

// File: rtl/bus_idle_seq.sv
module bus_idle_seq #(
  parameter int N_AREAS = 8,
  localparam int AW = $clog2(N_AREAS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic               cfg_rr_in,
  input  logic               cfg_wr_in,
  input  logic               cfg_dram_in,
  input  logic [N_AREAS-1:0] cfg_slow_in,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [AW-1:0]      req_area,
  input  logic               req_write,
  input  logic               req_dram,
  output logic [2:0]         bus_state,
  output logic [AW-1:0]      bus_area,
  output logic               rd_o,
  output logic               wr_o
);
  localparam logic [2:0] S_IDLE = 3'd0, S_TI = 3'd1, S_T1 = 3'd2, S_T2 = 3'd3, S_T3 = 3'd4;

  logic               en_rr, en_wr, en_dram;
  logic [N_AREAS-1:0] slow;
  logic [2:0]         st;
  logic [AW-1:0]      cur_area;
  logic               cur_write, cur_dram;
  logic               last_st, accept, need_idle;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      en_rr <= 1'b1; en_wr <= 1'b1; en_dram <= 1'b1;
      slow  <= '1;
    end else if (cfg_we) begin
      en_rr <= cfg_rr_in; en_wr <= cfg_wr_in; en_dram <= cfg_dram_in;
      slow  <= cfg_slow_in;
    end

  assign last_st   = (st == S_T3) || (st == S_T2 && !slow[cur_area]);
  assign req_ready = (st == S_IDLE) || last_st;
  assign accept    = req_valid && req_ready;

  // history exists only when the new cycle follows a completing one
  assign need_idle = last_st && (
      (en_rr   && !cur_write && !req_write && cur_area != req_area) ||
      (en_wr   && !cur_write &&  req_write) ||
      (en_dram &&  cur_dram  && !req_dram));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st        <= S_IDLE;
      cur_area  <= '0;
      cur_write <= 1'b0;
      cur_dram  <= 1'b0;
    end else if (accept) begin
      st        <= need_idle ? S_TI : S_T1;
      cur_area  <= req_area;
      cur_write <= req_write;
      cur_dram  <= req_dram;
    end else begin
      case (st)
        S_TI:    st <= S_T1;
        S_T1:    st <= S_T2;
        S_T2:    st <= slow[cur_area] ? S_T3 : S_IDLE;
        default: st <= S_IDLE;
      endcase
    end

  assign bus_state = st;
  assign bus_area  = cur_area;
  assign rd_o      = !cur_write && (st == S_T1 || st == S_T2 || st == S_T3);
  assign wr_o      =  cur_write && (st == S_T2 || st == S_T3);

  // R9
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(rd_o && wr_o));
  // R7
  ti_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_state == S_TI |-> !rd_o && !wr_o);
  // R7
  ti_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_state == S_TI |=> bus_state == S_T1);
  // R2
  t1_t2_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_state == S_T1 |=> bus_state == S_T2 && $stable(bus_area));
  // R2
  t3_after_t2_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_state == S_T3 |-> $past(bus_state) == S_T2);
  // R8
  no_ti_from_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bus_state) == S_IDLE |-> bus_state != S_TI);
  // R10
  ready_mid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_state == S_TI || bus_state == S_T1) |-> !req_ready);
endmodule

// File: tb/tb_bus_idle_seq.sv
module tb_bus_idle_seq;
  localparam int CLK_PERIOD = 10;

  logic       clk = 0, rst_n = 0;
  logic       cfg_we = 0, cfg_rr_in = 1, cfg_wr_in = 1, cfg_dram_in = 1;
  logic [7:0] cfg_slow_in = '1;
  logic       req_valid = 0, req_write = 0, req_dram = 0;
  logic [2:0] req_area = 0;
  logic       req_ready, rd_o, wr_o;
  logic [2:0] bus_state, bus_area;

  int errors = 0, checks = 0, cyc = 0;
  logic m_rr = 1, m_wr = 1, m_dram = 1;
  logic [7:0] m_slow = '1;

  bus_idle_seq dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      errors = errors + 1;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_cfg(input logic rr, input logic wr, input logic dr, input logic [7:0] sl);
    @(negedge clk);
    cfg_we = 1; cfg_rr_in = rr; cfg_wr_in = wr; cfg_dram_in = dr; cfg_slow_in = sl;
    @(negedge clk);
    cfg_we = 0;
    m_rr = rr; m_wr = wr; m_dram = dr; m_slow = sl;
  endtask

  function automatic bit exp_ti(input logic [2:0] aa, input logic wa, input logic da,
                                input logic [2:0] ab, input logic wb, input logic db);
    return (m_rr && !wa && !wb && aa != ab) || (m_wr && !wa && wb) || (m_dram && da && !db);
  endfunction

  // walks one cycle from T1 to IDLE, checking strobes, ready and length
  task automatic run_out(input logic w, input logic [2:0] a, input string tag);
    int n = 0;
    int len = m_slow[a] ? 3 : 2;
    while (bus_state != 3'd0 && n < 6) begin
      n++;
      chk(rd_o == (!w) && wr_o == (w && n >= 2), "R9", {rd_o, wr_o}, {!w, w && n >= 2});
      chk(req_ready == (n == len), "R10", req_ready, n == len);
      @(negedge clk);
    end
    chk(n == len, {"R2 ", tag}, n, len);
  endtask

  task automatic pair(input logic [2:0] aa, input logic wa, input logic da,
                      input logic [2:0] ab, input logic wb, input logic db,
                      input bit gap, input string tag);
    bit e;
    @(negedge clk);
    req_valid = 1; req_area = aa; req_write = wa; req_dram = da;
    @(negedge clk);
    chk(bus_state == 3'd2, "R8 first from idle", bus_state, 2);
    if (gap) begin
      req_valid = 0;
      while (bus_state != 3'd0) @(negedge clk);
      req_valid = 1;
      e = 0;
    end else begin
      e = exp_ti(aa, wa, da, ab, wb, db);
      while (!req_ready) @(negedge clk);
    end
    req_area = ab; req_write = wb; req_dram = db;
    @(negedge clk);
    req_valid = 0;
    if (e) begin
      chk(bus_state == 3'd1, tag, bus_state, 1);
      chk(!rd_o && !wr_o && bus_area == ab, "R7 quiet Ti", {rd_o, wr_o}, 0);
      @(negedge clk);
    end
    chk(bus_state == 3'd2, {tag, " T1"}, bus_state, 2);
    run_out(wb, ab, tag);
  endtask

  task automatic t_reset();
    chk(bus_state == 0 && !rd_o && !wr_o, "R1 reset state", bus_state, 0);
    chk(req_ready == 1, "R1 ready", req_ready, 1);
    pair(3'd1, 0, 0, 3'd2, 0, 0, 0, "R1 default rule on (R3)");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    pair(3'd3, 0, 0, 3'd3, 0, 0, 0, "R3 same area");
    pair(3'd0, 0, 0, 3'd5, 1, 0, 0, "R4 write after read");
    pair(3'd2, 1, 0, 3'd2, 1, 0, 0, "R4 write after write");
    pair(3'd4, 1, 1, 3'd4, 1, 0, 0, "R5 nondram after dram");
    pair(3'd4, 0, 1, 3'd4, 0, 1, 0, "R5 dram after dram");
    pair(3'd1, 0, 0, 3'd6, 0, 0, 1, "R8 gap clears history");
    set_cfg(0, 1, 1, 8'b0000_1111);
    pair(3'd1, 0, 0, 3'd6, 0, 0, 0, "R6 rr off / R2 mixed");
    set_cfg(1, 0, 1, 8'h00);
    pair(3'd0, 0, 0, 3'd0, 1, 0, 0, "R6 wr off");
    set_cfg(1, 1, 0, 8'hF0);
    pair(3'd5, 1, 1, 3'd7, 1, 0, 0, "R6 dram off");
    set_cfg(1, 1, 1, 8'b1010_0101);
    pair(3'd0, 0, 0, 3'd1, 0, 0, 0, "R3 two-state diff area");
    pair(3'd2, 0, 0, 3'd3, 1, 0, 0, "R4 R10 back to back");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule